// File: doc/BRIEF.md
# Amplitude-Keyed Carrier Synthesiser

The block produces the digital sample stream of an amplitude-keyed sine carrier for a power-line modem transmitter. A free-running phase counter walks a 64-point sine table once every 64 master-clock cycles, so the carrier frequency is exactly one sixty-fourth of the clock (8.48 MHz gives 132.5 kHz). Each table sample is scaled by an envelope level. The level climbs or falls by one step per carrier period, so keying never switches the amplitude abruptly.

The keying input is active low. While it is held low the envelope rises to full scale and stays there for as many bit periods as the line stays low. When it goes high the envelope decays back to zero. The result is a 6-bit code for an external DAC, centred on mid-code 32. An output-enable shows when the line driver should leave its high-impedance state, and a flag marks the keyed interval. A power-down input stops all generation and leaves only the clock running.

Top module: `ask_carrier_gen`

## Requirements
- R1: While rst_ni is low, and after reset before any keying, dac_o is 32, oe_o is 0 and tx_active_o is 0.
- R2: The phase index advances by one every clock and wraps from 63 to 0. The unscaled sample at phase k is s(k) = round(31*sin(2*pi*k/64)), rounded half away from zero, so the carrier period is 64 clocks.
- R3: data_ni is sampled only in the clock cycle where the phase is 63. A low sample sets the internal key and a high sample clears it. tx_active_o shows the key one clock later.
- R4: The envelope level runs from 0 to 8. At each phase-63 sample it moves one step toward 8 when keyed and toward 0 otherwise. One clock after state (phase k, level L), dac_o = 32 + floor(s(k)*L/8).
- R5: While data_ni stays low over many consecutive bit periods, the level stays at 8 and oe_o stays 1 with no dip. Full-scale codes reach 63 at the peak and 1 at the trough.
- R6: If data_ni returns low while the envelope is falling, the level turns around at the next phase-63 sample from its current value, without passing through zero. oe_o stays 1.
- R7: oe_o is 1 exactly when the key is set or the level is nonzero, one clock after that state. While oe_o is 0, dac_o is 32.
- R8: A clock edge with pd_i high clears the phase, level and key. It also drives dac_o to 32, oe_o to 0 and tx_active_o to 0. While pd_i stays high, data_ni has no effect.
- R9: A low pulse on data_ni that does not cover a phase-63 cycle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| data_ni | input | 1 | keying input, low requests a burst |
| pd_i | input | 1 | power-down, active high |
| dac_o | output | 6 | sample code for the DAC, 32 is zero level |
| oe_o | output | 1 | driver enable, 0 means high impedance |
| tx_active_o | output | 1 | keyed-interval flag |

## Verification
The hardest case to reach is a reversal in the middle of a ramp-down. The keying line must rise, stay high for only a few carrier periods, and fall again before the level reaches zero. The bench holds the line low until the envelope is full, releases it for three carrier periods, and then lowers it again. A per-cycle reference model checks every sample of the turnaround. A directed check confirms that the driver enable never drops. Glitch rejection is exercised by placing a short low pulse at a phase chosen away from the sampling cycle.

// File: rtl/ask_pkg.sv
package ask_pkg;
  localparam int PH_W  = 6;   // 64 samples per carrier period
  localparam int SMP_W = 7;   // signed sample, -31..31
  localparam int DAC_W = 6;
  localparam logic [DAC_W-1:0] DAC_MID = 6'd32;

  // first quadrant of 31*sin, index 0..16
  function automatic logic [4:0] quarter_sin(input logic [4:0] k);
    case (k)
      5'd0:  quarter_sin = 5'd0;
      5'd1:  quarter_sin = 5'd3;
      5'd2:  quarter_sin = 5'd6;
      5'd3:  quarter_sin = 5'd9;
      5'd4:  quarter_sin = 5'd12;
      5'd5:  quarter_sin = 5'd15;
      5'd6:  quarter_sin = 5'd17;
      5'd7:  quarter_sin = 5'd20;
      5'd8:  quarter_sin = 5'd22;
      5'd9:  quarter_sin = 5'd24;
      5'd10: quarter_sin = 5'd26;
      5'd11: quarter_sin = 5'd27;
      5'd12: quarter_sin = 5'd29;
      5'd13: quarter_sin = 5'd30;
      5'd14: quarter_sin = 5'd30;
      default: quarter_sin = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/ask_phase_cnt.sv
module ask_phase_cnt
  import ask_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pd_i,
  output logic [PH_W-1:0] ph_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_o <= '0;
    else if (pd_i) ph_o <= '0;
    else           ph_o <= ph_o + 1'b1;
  end

  assign wrap_o = (ph_o == PH_LAST);

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !pd_i) |=> (ph_o == '0));
  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_o && !pd_i) |=> (ph_o == $past(ph_o) + 1'b1));
endmodule

// File: rtl/ask_sine_rom.sv
module ask_sine_rom
  import ask_pkg::*;
(
  input  logic [PH_W-1:0]         ph_i,
  output logic signed [SMP_W-1:0] smp_o
);
  logic [3:0] j;
  logic [4:0] idx;
  logic [4:0] mag;

  assign j   = ph_i[3:0];
  assign idx = ph_i[4] ? (5'd16 - {1'b0, j}) : {1'b0, j};
  assign mag = quarter_sin(idx);
  assign smp_o = ph_i[5] ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
endmodule

// File: rtl/ask_env_ramp.sv
module ask_env_ramp #(
  parameter int RAMP_LOG2 = 3,
  localparam int STEPS = 1 << RAMP_LOG2,
  localparam int LVL_W = RAMP_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             wrap_i,
  input  logic             key_req_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             key_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(STEPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o <= 1'b0;
      lvl_o <= '0;
    end else if (pd_i) begin
      key_o <= 1'b0;
      lvl_o <= '0;
    end else if (wrap_i) begin
      key_o <= key_req_i;
      if (key_req_i && lvl_o != LVL_MAX)  lvl_o <= lvl_o + 1'b1;
      else if (!key_req_i && lvl_o != '0) lvl_o <= lvl_o - 1'b1;
    end
  end

  // R4
  lvl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o <= LVL_MAX);
  // R9
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && !pd_i) |=> ($stable(lvl_o) && $stable(key_o)));
  // R6
  lvl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !pd_i) |=> (lvl_o == $past(lvl_o) + 1'b1 ||
                           lvl_o == $past(lvl_o) - 1'b1 || $stable(lvl_o)));
endmodule

// File: rtl/ask_carrier_gen.sv
module ask_carrier_gen
  import ask_pkg::*;
#(
  parameter int RAMP_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_ni,
  input  logic             pd_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             oe_o,
  output logic             tx_active_o
);
  localparam int LVL_W = RAMP_LOG2 + 1;
  localparam int PW    = SMP_W + LVL_W + 1;

  logic [PH_W-1:0]         ph;
  logic                    wrap;
  logic signed [SMP_W-1:0] smp;
  logic [LVL_W-1:0]        lvl;
  logic                    key;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    scaled;
  logic [DAC_W-1:0]        dac_d;

  ask_phase_cnt u_phase (
    .clk_i, .rst_ni, .pd_i, .ph_o(ph), .wrap_o(wrap)
  );

  ask_sine_rom u_rom (.ph_i(ph), .smp_o(smp));

  ask_env_ramp #(.RAMP_LOG2(RAMP_LOG2)) u_env (
    .clk_i, .rst_ni, .pd_i, .wrap_i(wrap), .key_req_i(~data_ni),
    .lvl_o(lvl), .key_o(key)
  );

  // floor scaling, level 2^RAMP_LOG2 is unity
  assign prod   = smp * $signed({1'b0, lvl});
  assign scaled = prod >>> RAMP_LOG2;
  assign dac_d  = DAC_W'(scaled + $signed(PW'(DAC_MID)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_o       <= DAC_MID;
      oe_o        <= 1'b0;
      tx_active_o <= 1'b0;
    end else if (pd_i) begin
      dac_o       <= DAC_MID;
      oe_o        <= 1'b0;
      tx_active_o <= 1'b0;
    end else begin
      dac_o       <= dac_d;
      oe_o        <= key || (lvl != '0);
      tx_active_o <= key;
    end
  end

  // R7
  idle_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (dac_o == DAC_MID));
  // R8
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!oe_o && !tx_active_o && dac_o == DAC_MID));
  // R3
  tx_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> oe_o);
endmodule

// File: tb/ask_carrier_gen_bench.sv
module ask_carrier_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_n = 1'b1;
  logic pd = 1'b0;
  logic [5:0] dac;
  logic oe, tx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ask_carrier_gen u_ask_carrier_gen (
    .clk_i(clk), .rst_ni(rst_n), .data_ni(data_n), .pd_i(pd),
    .dac_o(dac), .oe_o(oe), .tx_active_o(tx)
  );

  function automatic int sine_ref(input int k);
    real x;
    x = 31.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    return int'(x);
  endfunction

  // reference model
  int m_ph = 0, m_lvl = 0;
  bit m_key = 0;
  int e_dac = 32;
  bit e_oe = 0, e_tx = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || pd) begin
      m_ph = 0; m_lvl = 0; m_key = 0;
      e_dac = 32; e_oe = 0; e_tx = 0;
    end else begin
      int p;
      p = sine_ref(m_ph) * m_lvl;
      e_dac = 32 + (p >>> 3);
      e_oe  = m_key || (m_lvl != 0);
      e_tx  = m_key;
      if (m_ph == 63) begin
        m_key = !data_n;
        if (!data_n && m_lvl < STEPS) m_lvl++;
        else if (data_n && m_lvl > 0) m_lvl--;
      end
      m_ph = (m_ph + 1) % 64;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(dac == 6'(e_dac), cur_req, "dac_o", int'(dac), e_dac);
      check(oe == e_oe, cur_req, "oe_o", int'(oe), int'(e_oe));
      check(tx == e_tx, cur_req, "tx_active_o", int'(tx), int'(e_tx));
    end
  end

  task automatic drive(input logic dn, input logic p, input int n);
    data_n = dn;
    pd = p;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mx, mn;
    bit dipped;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(dac == 6'd32 && !oe && !tx, "R1", "reset outputs", int'(dac), 32);
    rst_n = 1'b1;
    cur_req = "R1";
    drive(1, 0, 100);
    check(!oe && dac == 6'd32, "R1", "idle after reset", int'(oe), 0);

    // R9 short low pulse away from phase 63
    cur_req = "R9";
    while (m_ph != 10) @(negedge clk);
    drive(0, 0, 5);
    dipped = 0;
    for (int i = 0; i < 80; i++) begin
      data_n = 1'b1;
      @(negedge clk);
      if (oe || tx) dipped = 1;
    end
    check(!dipped, "R9", "glitch ignored", int'(dipped), 0);

    // R3 R4 ramp up, R2 sample shape checked by model
    cur_req = "R4";
    drive(0, 0, 64 * 9);
    check(tx == 1'b1, "R3", "tx_active after keying", int'(tx), 1);

    // R5 NRZ run of consecutive low bits
    cur_req = "R5";
    mx = 0; mn = 63; dipped = 0;
    for (int i = 0; i < 64 * 12; i++) begin
      data_n = 1'b0;
      @(negedge clk);
      if (int'(dac) > mx) mx = int'(dac);
      if (int'(dac) < mn) mn = int'(dac);
      if (!oe) dipped = 1;
    end
    check(mx == 63, "R5", "peak code", mx, 63);
    check(mn == 1, "R5", "trough code", mn, 1);
    check(!dipped, "R5", "oe held", int'(dipped), 0);
    cur_req = "R2";
    drive(0, 0, 128);

    // R6 reversal during ramp-down
    cur_req = "R6";
    dipped = 0;
    for (int i = 0; i < 64 * 3 + 20; i++) begin
      data_n = 1'b1;
      @(negedge clk);
      if (!oe) dipped = 1;
    end
    for (int i = 0; i < 64 * 8; i++) begin
      data_n = 1'b0;
      @(negedge clk);
      if (!oe) dipped = 1;
    end
    check(!dipped, "R6", "oe during reversal", int'(dipped), 0);

    // R7 full ramp-down to idle
    cur_req = "R7";
    drive(1, 0, 64 * 10);
    check(!oe && dac == 6'd32, "R7", "idle after decay", int'(dac), 32);
    check(!tx, "R3", "tx_active cleared", int'(tx), 0);

    // R8 power-down during burst
    cur_req = "R8";
    drive(0, 0, 64 * 5);
    drive(0, 1, 1);
    check(!oe && !tx && dac == 6'd32, "R8", "pd clears outputs", int'(dac), 32);
    dipped = 0;
    for (int i = 0; i < 200; i++) begin
      data_n = 1'b0;
      pd = 1'b1;
      @(negedge clk);
      if (oe || tx || dac != 6'd32) dipped = 1;
    end
    check(!dipped, "R8", "data ignored in pd", int'(dipped), 0);
    drive(0, 0, 64 * 4);
    check(oe == 1'b1, "R8", "restart after pd", int'(oe), 1);
    drive(1, 0, 64 * 10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule